// File: doc/BRIEF.md
# Pipelined data-port memory responder

This block sits on the memory side of a processor core's data port and answers its requests from a small internal word store. The core presents an address, a direction bit and a two-bit cycle-type code one clock before the transfer they describe. The responder registers that control and decodes it. In the next clock, the transfer cycle, it returns read data, stores the write data that the core holds during that cycle, or leaves the store alone.

An abort flag marks accesses that fall inside a forbidden address window set by parameters. The flag is raised in the transfer cycle, alongside the data. A parameter can switch abort detection off, and the flag is then tied low. For sequential accesses the block also checks that the address follows on from the last memory access. A sticky flag records any break in that chain.

Top module: `dport_mem_responder`

## Requirements
- R1: Only cycle codes `{req_n_i,seq_i}` = 00 (non-sequential) and 01 (sequential) access the store; a write requested under code 10 (idle) or 11 (coprocessor) leaves the store unchanged.
- R2: For a read registered at one rising edge, `rdata_o` shows the stored word during the cycle that follows, and that cycle is the transfer cycle.
- R3: For a write registered at one rising edge, `wdata_i` is sampled at the end of the transfer cycle and is returned by any later read of the same word.
- R4: In the transfer cycle of an idle (10) cycle, `rdata_o` keeps the value it had in the previous cycle.
- R5: In the transfer cycle of a coprocessor (11) cycle, `rdata_o` keeps its previous value and `abort_o` stays low.
- R6: With abort detection enabled, `abort_o` is high in the transfer cycle of a 00 or 01 access whose address lies in [ABT_LO, ABT_HI] inclusive, and low in every other cycle.
- R7: An aborted write leaves the addressed word unchanged.
- R8: An aborted read drives `rdata_o` to zero in its transfer cycle.
- R9: With ABORT_ENABLE = 0, `abort_o` is low in every cycle.
- R10: A sequential (01) access whose address is not the address of the last 00/01 access plus 4 sets `proto_err_o`. So does a sequential access with no 00/01 access since reset. The flag rises after that access's transfer cycle and stays high until reset.
- R11: A synchronous active-low reset clears `abort_o`, `proto_err_o` and the held read value to zero, and registers an idle cycle.
- R12: A word is selected by address bits [9:2], so addresses that differ only above bit 9 alias to the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_n_i | input | 1 | Cycle code high bit; low requests a memory access |
| seq_i | input | 1 | Cycle code low bit; sequential marker |
| write_i | input | 1 | Direction: 0 read, 1 write |
| addr_i | input | 32 | Byte address, one cycle ahead of data |
| wdata_i | input | 32 | Write data, held during the transfer cycle |
| rdata_o | output | 32 | Read data or held value |
| abort_o | output | 1 | Abort flag, timed with the data |
| proto_err_o | output | 1 | Sticky sequential-address error |

## Verification
Because control runs one cycle ahead of data, each clock carries the write data of one transfer and the address of the next. A write followed at once by a read of the same word therefore overlaps in a single cycle. The bench provokes this repeatedly, both directed and from the random stream. It judges the result by expecting the read to return the word just written, which the bench's own model stores at the end of the write's transfer cycle. A second overlap pairs an abort with a sequential-chain break in the same transfer. Both effects are checked independently: the abort flag in that cycle and the error flag one edge later.

// File: rtl/dport_pkg.sv
package dport_pkg;
    typedef enum logic [1:0] {
        CYC_NSEQ = 2'b00,
        CYC_SEQ  = 2'b01,
        CYC_IDLE = 2'b10,
        CYC_COP  = 2'b11
    } cyc_e;
endpackage

// File: rtl/dport_decode.sv
module dport_decode
    import dport_pkg::*;
(
    input  cyc_e cyc,
    output logic mem_access,
    output logic seq_access
);
    always_comb begin
        mem_access = (cyc == CYC_NSEQ) || (cyc == CYC_SEQ);
        seq_access = (cyc == CYC_SEQ);
    end
endmodule

// File: rtl/dport_abort_win.sv
module dport_abort_win #(
    parameter int          ADDR_W       = 32,
    parameter bit          ABORT_ENABLE = 1'b1,
    parameter logic [31:0] ABT_LO       = 32'h0000_0300,
    parameter logic [31:0] ABT_HI       = 32'h0000_03FF
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              active,
    output logic              hit
);
    generate
        if (ABORT_ENABLE) begin : g_window
            logic in_win;
            always_comb begin
                in_win = (addr >= ADDR_W'(ABT_LO)) && (addr <= ADDR_W'(ABT_HI));
                hit    = active && in_win;
            end
        end else begin : g_off
            logic unused_in;
            always_comb begin
                unused_in = active ^ (^addr);
                hit       = 1'b0;
            end
        end
    endgenerate
endmodule

// File: rtl/dport_ram.sv
module dport_ram #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 256,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[idx] <= wdata;
    end

    assign rdata = mem_q[idx];
endmodule

// File: rtl/dport_mem_responder.sv
module dport_mem_responder
    import dport_pkg::*;
#(
    parameter int          ADDR_W       = 32,
    parameter int          DATA_W       = 32,
    parameter int          DEPTH        = 256,
    parameter bit          ABORT_ENABLE = 1'b1,
    parameter logic [31:0] ABT_LO       = 32'h0000_0300,
    parameter logic [31:0] ABT_HI       = 32'h0000_03FF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_n_i,
    input  logic              seq_i,
    input  logic              write_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              abort_o,
    output logic              proto_err_o
);
    localparam int IDX_W  = $clog2(DEPTH);
    localparam int BYTE_W = $clog2(DATA_W / 8);

    typedef struct packed {
        cyc_e              cyc;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] hold;
        logic [ADDR_W-1:0] last;
        logic              last_vld;
        logic              err;
    } state_t;

    localparam state_t RST_VAL = '{cyc: CYC_IDLE, wr: 1'b0, addr: '0, hold: '0,
                                   last: '0, last_vld: 1'b0, err: 1'b0};

    state_t state_d, state_q;

    logic              mem_access;
    logic              seq_access;
    logic              abort_hit;
    logic              ram_we;
    logic [DATA_W-1:0] ram_rdata;
    logic [IDX_W-1:0]  ram_idx;

    dport_decode u_decode (
        .cyc        (state_q.cyc),
        .mem_access (mem_access),
        .seq_access (seq_access)
    );

    dport_abort_win #(
        .ADDR_W       (ADDR_W),
        .ABORT_ENABLE (ABORT_ENABLE),
        .ABT_LO       (ABT_LO),
        .ABT_HI       (ABT_HI)
    ) u_abort (
        .addr   (state_q.addr),
        .active (mem_access),
        .hit    (abort_hit)
    );

    assign ram_idx = state_q.addr[BYTE_W +: IDX_W];

    dport_ram #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH)
    ) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .idx   (ram_idx),
        .wdata (wdata_i),
        .rdata (ram_rdata)
    );

    always_comb begin
        state_d = state_q;

        // data phase of the registered transfer
        ram_we = mem_access && state_q.wr && !abort_hit;
        if (mem_access && !state_q.wr) begin
            rdata_o = abort_hit ? '0 : ram_rdata;
        end else begin
            rdata_o = state_q.hold;
        end
        state_d.hold = rdata_o;

        // sequential address chain check
        if (seq_access &&
            (!state_q.last_vld || (state_q.addr != state_q.last + ADDR_W'(4)))) begin
            state_d.err = 1'b1;
        end
        if (mem_access) begin
            state_d.last     = state_q.addr;
            state_d.last_vld = 1'b1;
        end

        // address phase of the next transfer
        state_d.cyc  = cyc_e'({req_n_i, seq_i});
        state_d.wr   = write_i;
        state_d.addr = addr_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RST_VAL;
        else        state_q <= state_d;
    end

    assign abort_o     = abort_hit;
    assign proto_err_o = state_q.err;
endmodule

// File: rtl/dport_mem_responder_chk.sv
module dport_mem_responder_chk #(
    parameter int          ADDR_W       = 32,
    parameter int          DATA_W       = 32,
    parameter bit          ABORT_ENABLE = 1'b1,
    parameter logic [31:0] ABT_LO       = 32'h0000_0300,
    parameter logic [31:0] ABT_HI       = 32'h0000_03FF
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_n_i,
    input logic              seq_i,
    input logic              write_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [DATA_W-1:0] rdata_o,
    input logic              abort_o,
    input logic              proto_err_o
);
    logic in_win;
    assign in_win = (addr_i >= ADDR_W'(ABT_LO)) && (addr_i <= ADDR_W'(ABT_HI));

    AST_ABORT_TIMED: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |-> ($past(rst_n) && $past(!req_n_i) && $past(in_win)))
        else $error("abort without prior in-window access"); // R6

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(req_n_i && !seq_i)) |-> $stable(rdata_o))
        else $error("read data moved in idle transfer"); // R4

    AST_COP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(req_n_i && seq_i)) |-> ($stable(rdata_o) && !abort_o))
        else $error("coprocessor transfer disturbed data or abort"); // R5

    AST_ABORT_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_o && $past(!write_i)) |-> (rdata_o == '0))
        else $error("aborted read returned data"); // R8

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(proto_err_o)) |-> proto_err_o)
        else $error("protocol error flag dropped"); // R10

    AST_ABORT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (ABORT_ENABLE == 1'b0) |-> !abort_o)
        else $error("abort raised while disabled"); // R9
endmodule

bind dport_mem_responder dport_mem_responder_chk #(
    .ADDR_W       (ADDR_W),
    .DATA_W       (DATA_W),
    .ABORT_ENABLE (ABORT_ENABLE),
    .ABT_LO       (ABT_LO),
    .ABT_HI       (ABT_HI)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_n_i     (req_n_i),
    .seq_i       (seq_i),
    .write_i     (write_i),
    .addr_i      (addr_i),
    .rdata_o     (rdata_o),
    .abort_o     (abort_o),
    .proto_err_o (proto_err_o)
);

// File: tb/dport_mem_responder_bench.sv
module dport_mem_responder_bench;
    localparam logic [1:0] C_NS = 2'b00, C_SQ = 2'b01, C_ID = 2'b10, C_CP = 2'b11;
    localparam logic [31:0] LO = 32'h300, HI = 32'h3FF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_n_i = 1'b1, seq_i = 1'b0, write_i = 1'b0;
    logic [31:0] addr_i = '0, wdata_i = '0;
    logic [31:0] rdata_o, rdata_off;
    logic        abort_o, abort_off, err_o, err_off;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    dport_mem_responder u_dport_mem_responder (
        .clk(clk), .rst_n(rst_n), .req_n_i(req_n_i), .seq_i(seq_i), .write_i(write_i),
        .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .abort_o(abort_o),
        .proto_err_o(err_o));

    dport_mem_responder #(.ABORT_ENABLE(1'b0)) u_noabort (
        .clk(clk), .rst_n(rst_n), .req_n_i(req_n_i), .seq_i(seq_i), .write_i(write_i),
        .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_off), .abort_o(abort_off),
        .proto_err_o(err_off));

    // reference model
    logic [31:0] m_mem [256];
    logic [31:0] m_hold, m_last;
    logic        m_last_vld, m_err;
    logic [1:0]  p_cyc;
    logic        p_we;
    logic [31:0] p_addr, p_wd;
    string       tag_ovr = "";

    function automatic logic in_win(input logic [31:0] a);
        return (a >= LO) && (a <= HI);
    endfunction

    function automatic logic is_acc(input logic [1:0] c);
        return (c == C_NS) || (c == C_SQ);
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Called at a negedge: checks the pending transfer, then issues a new control phase.
    task automatic step(input logic [1:0] cyc, input logic we, input logic [31:0] a,
                        input logic [31:0] wd);
        logic        e_abt;
        logic [31:0] e_rd;
        string       t;
        e_abt = is_acc(p_cyc) && in_win(p_addr);
        if (is_acc(p_cyc) && !p_we) e_rd = e_abt ? 32'h0 : m_mem[p_addr[9:2]];
        else                        e_rd = m_hold;
        if (p_cyc == C_ID)                  t = "R4";
        else if (p_cyc == C_CP)             t = "R5";
        else if (p_we)                      t = "R3";
        else if (e_abt)                     t = "R8";
        else                                t = "R2";
        if (tag_ovr != "") t = tag_ovr;
        chk(rdata_o, e_rd, t);
        chk({31'b0, abort_o}, {31'b0, e_abt}, (p_cyc == C_CP) ? "R5" : "R6");
        chk({31'b0, abort_off}, 32'h0, "R9");
        chk({31'b0, err_o}, {31'b0, m_err}, "R10");
        wdata_i = p_wd;
        req_n_i = cyc[1]; seq_i = cyc[0]; write_i = we; addr_i = a;
        @(posedge clk);
        // model update at the end of the transfer cycle
        if (is_acc(p_cyc) && p_we && !e_abt) m_mem[p_addr[9:2]] = p_wd;
        m_hold = e_rd;
        if (p_cyc == C_SQ && (!m_last_vld || p_addr != m_last + 32'd4)) m_err = 1'b1;
        if (is_acc(p_cyc)) begin m_last = p_addr; m_last_vld = 1'b1; end
        p_cyc = cyc; p_we = we; p_addr = a; p_wd = wd;
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; req_n_i = 1'b1; seq_i = 1'b0; write_i = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_hold = '0; m_err = 1'b0; m_last_vld = 1'b0; m_last = '0;
        p_cyc = C_ID; p_we = 1'b0; p_addr = '0; p_wd = '0;
        @(posedge clk);
        @(negedge clk);
        chk(rdata_o, 32'h0, "R11");
        chk({31'b0, abort_o}, 32'h0, "R11");
        chk({31'b0, err_o}, 32'h0, "R11");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        do_reset();
        // fill every word: non-sequential start, sequential chain
        for (int i = 0; i < 256; i++)
            step((i == 0) ? C_NS : C_SQ, 1'b1, 32'(i * 4), 32'hA500_0000 + 32'(i));
        step(C_ID, 1'b0, 32'h0, 32'h0);
        // R2/R3 back-to-back write then read of the same word
        step(C_NS, 1'b1, 32'h10, 32'hDEAD_BEEF);
        step(C_NS, 1'b0, 32'h10, 32'h0);
        step(C_ID, 1'b0, 32'h0, 32'h0);  // R4 hold of DEAD_BEEF
        step(C_ID, 1'b0, 32'h0, 32'h0);
        // R1 write request under coprocessor and idle codes must not store
        step(C_CP, 1'b1, 32'h20, 32'h1111_1111);
        step(C_ID, 1'b1, 32'h24, 32'h2222_2222);
        tag_ovr = "R1";
        step(C_NS, 1'b0, 32'h20, 32'h0);
        step(C_NS, 1'b0, 32'h24, 32'h0);
        step(C_ID, 1'b0, 32'h0, 32'h0);
        tag_ovr = "";
        // R7 aborted write, read back through alias outside window (R12)
        step(C_NS, 1'b1, 32'h300, 32'h7777_7777);
        step(C_NS, 1'b0, 32'h300, 32'h0);   // R8 aborted read
        tag_ovr = "R7";
        step(C_NS, 1'b0, 32'h700, 32'h0);
        tag_ovr = "R12";
        step(C_NS, 1'b1, 32'h404, 32'h4040_4040);
        step(C_NS, 1'b0, 32'h004, 32'h0);
        step(C_ID, 1'b0, 32'h0, 32'h0);
        tag_ovr = "";
        // R10 sequential chain intact, then broken together with an abort
        step(C_NS, 1'b0, 32'h2F8, 32'h0);
        step(C_SQ, 1'b0, 32'h2FC, 32'h0);
        step(C_SQ, 1'b0, 32'h308, 32'h0);
        step(C_ID, 1'b0, 32'h0, 32'h0);
        step(C_ID, 1'b0, 32'h0, 32'h0);
        // R11 reset clears the sticky flag; R10 sequential with no prior access
        do_reset();
        step(C_SQ, 1'b0, 32'h8, 32'h0);
        step(C_ID, 1'b0, 32'h0, 32'h0);
        step(C_ID, 1'b0, 32'h0, 32'h0);
        do_reset();
        // random mix
        for (int n = 0; n < 3000; n++) begin
            logic [1:0]  c;
            logic [31:0] a;
            int          r;
            r = int'($urandom % 10);
            c = (r < 4) ? C_NS : (r < 7) ? C_SQ : (r < 9) ? C_ID : C_CP;
            a = {20'b0, 2'($urandom), 8'($urandom), 2'b00};
            if (c == C_SQ && ($urandom % 8) != 0) a = m_last_next();
            step(c, 1'($urandom), a, $urandom);
        end
        step(C_ID, 1'b0, 32'h0, 32'h0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // next sequential address after the most recent access, including the pending one
    function automatic logic [31:0] m_last_next();
        if (is_acc(p_cyc)) return p_addr + 32'd4;
        return m_last + 32'd4;
    endfunction
endmodule